// File: doc/BRIEF.md
# Multi-Mode Receive Status Register

This block holds the eight status flags that a serial receiver raises while it takes in characters. The receiver works in asynchronous, byte synchronous or bit synchronous (HDLC-like) mode. The datapath sends one-cycle event strobes: framing error, residual bit on the last information character, residual bit on the last check-sequence character, overrun, CRC error, abort and end of message. The block turns these strobes into sticky flags. Which strobes count depends on the mode, and some of them also raise the end-of-message flag.

Software reads the flags as one 8-bit value. It clears a flag by writing 1 to that flag's bit position. There are two other ways to clear flags. A synchronous receiver reset clears all of them. In bit synchronous mode, a frame-status load strobe also clears all of them, because it hands the current status to the frame status queue. If a new event and a clear by software or by frame-status load arrive in the same cycle, the event wins, so no event is lost.

Top module: `rx_status_reg`

## Requirements
- R1: Bits 6, 1 and 0 always read 0, and writing 0 or 1 to them changes nothing.
- R2: Bit 3 (overrun) is set by `ev_overrun` in modes 0, 1 and 2 (0 = asynchronous, 1 = byte synchronous, 2 = bit synchronous). Mode code 3 is reserved: in mode 3 no event strobe sets any bit.
- R3: Bit 4 is set by `ev_framing` in mode 0 and by the selected residual strobe in mode 2. Nothing sets it in mode 1.
- R4: In mode 2, when `cfg_crc_xfer` is 1, `ev_resid_info` sets bit 4 and `ev_resid_fcs` is ignored. When `cfg_crc_xfer` is 0, the two strobes swap roles.
- R5: Bit 2 (CRC error) is set by `ev_crc` only in modes 1 and 2.
- R6: Bit 5 (abort) is set by `ev_abort` only in mode 2, and it sets bit 7 in the same cycle.
- R7: Bit 7 (end of message) is set by `ev_eom` in modes 1 and 2. A residual event that sets bit 4 in mode 2 also sets bit 7.
- R8: A set flag stays set until it is cleared. A write with `wr_en` high clears every flag whose bit in `wr_data` is 1 and leaves the others alone.
- R9: An event that sets a bit in the same cycle as a software clear or a frame-status load of that bit wins, and the bit reads 1 afterwards.
- R10: `fs_load` in mode 2 clears all bits in one cycle. In modes 0, 1 and 3 it has no effect.
- R11: `rcv_reset` clears all bits in one cycle and overrides any event in that cycle.
- R12: When `rst_n` is sampled low at a clock edge, all bits become 0.
- R13: `eom_flag` always equals bit 7 of `rd_data`.
- All flag changes show on `rd_data` one clock edge after the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Receive mode: 0 async, 1 byte sync, 2 bit sync, 3 reserved |
| cfg_crc_xfer | input | 1 | 1 when the check sequence is passed on to the buffer |
| rcv_reset | input | 1 | Synchronous receiver reset; clears all flags |
| fs_load | input | 1 | Frame status handed off (clears all flags in bit sync mode) |
| ev_framing | input | 1 | Framing error strobe |
| ev_resid_info | input | 1 | Residual bit on the last information character |
| ev_resid_fcs | input | 1 | Residual bit on the last check-sequence character |
| ev_overrun | input | 1 | Overrun strobe |
| ev_crc | input | 1 | CRC error strobe |
| ev_abort | input | 1 | Abort seen after this character |
| ev_eom | input | 1 | End of message strobe |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Write-one-to-clear mask |
| rd_data | output | 8 | Current flag value |
| eom_flag | output | 1 | End-of-message flag (bit 7) |

## Verification
Every flag is a single register, so a wrong internal state is visible on `rd_data` on the very next clock edge. Examples are a flag that never sets, sets in the wrong mode, or drops without a clear. The bench compares the whole 8-bit value with a behavioural model on every cycle, so any such fault is reported in the cycle it appears. A fault in mode qualification appears only while that mode is selected. For that reason the stimulus visits every mode code, both residual selections, and clears that collide with events.

// File: rtl/rxs_pkg.sv
// Package rxs_pkg
// Shared register width, bit positions and mode codes for the receive
// status register. Assumes an 8-bit register with fixed flag positions.
package rxs_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_EOM   = 7;
    localparam int BIT_ABORT = 5;
    localparam int BIT_FRRB  = 4;   // framing error / residual bit
    localparam int BIT_OVRN  = 3;
    localparam int BIT_CRC   = 2;

    localparam logic [REG_W-1:0] LIVE_MASK =
        (REG_W'(1) << BIT_EOM)  | (REG_W'(1) << BIT_ABORT) |
        (REG_W'(1) << BIT_FRRB) | (REG_W'(1) << BIT_OVRN)  |
        (REG_W'(1) << BIT_CRC);
    localparam logic [REG_W-1:0] RSVD_MASK = ~LIVE_MASK;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_BYTE  = 2'd1,
        MODE_BIT   = 2'd2,
        MODE_NONE  = 2'd3
    } rx_mode_e;
endpackage

// File: rtl/rxs_event_qual.sv
// Module rxs_event_qual
// Turns the raw receiver strobes into a per-bit set vector, keeping only
// the events that count in the current mode and adding the forced
// end-of-message. Purely combinational; assumes strobes last one cycle.
module rxs_event_qual
    import rxs_pkg::*;
(
    input  rx_mode_e         mode,
    input  logic             cfg_crc_xfer,
    input  logic             ev_framing,
    input  logic             ev_resid_info,
    input  logic             ev_resid_fcs,
    input  logic             ev_overrun,
    input  logic             ev_crc,
    input  logic             ev_abort,
    input  logic             ev_eom,
    output logic [REG_W-1:0] set_vec
);
    logic resid_sel;

    // Pick the residual strobe that matches the check-sequence transfer setting.
    always_comb resid_sel = cfg_crc_xfer ? ev_resid_info : ev_resid_fcs;

    // Build the set vector for the selected mode.
    always_comb begin
        set_vec = '0;
        unique case (mode)
            MODE_ASYNC: begin
                set_vec[BIT_FRRB] = ev_framing;
                set_vec[BIT_OVRN] = ev_overrun;
            end
            MODE_BYTE: begin
                set_vec[BIT_OVRN] = ev_overrun;
                set_vec[BIT_CRC]  = ev_crc;
                set_vec[BIT_EOM]  = ev_eom;
            end
            MODE_BIT: begin
                set_vec[BIT_FRRB]  = resid_sel;
                set_vec[BIT_OVRN]  = ev_overrun;
                set_vec[BIT_CRC]   = ev_crc;
                set_vec[BIT_ABORT] = ev_abort;
                set_vec[BIT_EOM]   = ev_eom | ev_abort | resid_sel;
            end
            default: set_vec = '0;
        endcase
    end
endmodule

// File: rtl/rxs_clear_ctrl.sv
// Module rxs_clear_ctrl
// Forms the per-bit clear vector from the software write-one-to-clear
// port and the bit-synchronous frame-status hand-off. The receiver reset
// is handled separately in the flag cells because it outranks set events.
module rxs_clear_ctrl
    import rxs_pkg::*;
(
    input  rx_mode_e         mode,
    input  logic             fs_load,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] clr_vec
);
    // Merge the software clear with the frame-status clear.
    always_comb begin
        clr_vec = wr_en ? (wr_data & LIVE_MASK) : '0;
        if (fs_load && mode == MODE_BIT)
            clr_vec = LIVE_MASK;
    end
endmodule

// File: rtl/rxs_flag_cell.sv
// Module rxs_flag_cell
// One sticky status flag. Priority: chip reset, then receiver reset,
// then set, then clear. Assumes a synchronous active-low chip reset.
module rxs_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic rcv_reset,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    // Update the flag; a set event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || rcv_reset) flag_q <= 1'b0;
        else if (set_i)          flag_q <= 1'b1;
        else if (clr_i)          flag_q <= 1'b0;
    end
endmodule

// File: rtl/rx_status_reg.sv
// Module rx_status_reg
// Receive error/status register for a three-mode serial receiver. Event
// strobes set sticky flags, qualified by mode. Software clears flags by
// writing ones, and the receiver reset or a bit-synchronous frame-status
// hand-off clears all of them. Reserved positions read zero.
module rx_status_reg
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             cfg_crc_xfer,
    input  logic             rcv_reset,
    input  logic             fs_load,
    input  logic             ev_framing,
    input  logic             ev_resid_info,
    input  logic             ev_resid_fcs,
    input  logic             ev_overrun,
    input  logic             ev_crc,
    input  logic             ev_abort,
    input  logic             ev_eom,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             eom_flag
);
    rx_mode_e         mode_e;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] flags;

    // Give the raw mode code its enumerated type.
    always_comb mode_e = rx_mode_e'(mode);

    rxs_event_qual u_qual (
        .mode          (mode_e),
        .cfg_crc_xfer  (cfg_crc_xfer),
        .ev_framing    (ev_framing),
        .ev_resid_info (ev_resid_info),
        .ev_resid_fcs  (ev_resid_fcs),
        .ev_overrun    (ev_overrun),
        .ev_crc        (ev_crc),
        .ev_abort      (ev_abort),
        .ev_eom        (ev_eom),
        .set_vec       (set_vec)
    );

    rxs_clear_ctrl u_clr (
        .mode    (mode_e),
        .fs_load (fs_load),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr_vec (clr_vec)
    );

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (LIVE_MASK[i]) begin : g_live
            rxs_flag_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .rcv_reset (rcv_reset),
                .set_i     (set_vec[i]),
                .clr_i     (clr_vec[i]),
                .flag_q    (flags[i])
            );
        end else begin : g_rsvd
            assign flags[i] = 1'b0;
        end
    end

    // Drive the read value and the end-of-message output.
    always_comb begin
        rd_data  = flags;
        eom_flag = flags[BIT_EOM];
    end

    // R1: a write never makes a reserved bit readable as 1
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data & RSVD_MASK) == '0);

    // R2: a qualifying overrun is visible on the next cycle
    a_r2_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_overrun && mode != 2'd3 && !rcv_reset) |=> rd_data[BIT_OVRN]);

    // R6: abort in bit sync mode raises abort and end of message together
    a_r6_abort_eom: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_abort && mode == 2'd2 && !rcv_reset) |=> (rd_data[BIT_ABORT] && rd_data[BIT_EOM]));

    // R8: with no clear source active, flags only accumulate
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rcv_reset && !wr_en && !(fs_load && mode == 2'd2))
        |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

    // R10: a frame-status load with no competing event empties the register
    a_r10_fs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_load && mode == 2'd2 && !rcv_reset && set_vec == '0) |=> rd_data == '0);

    // R11: receiver reset empties the register in one cycle
    a_r11_rcv_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_reset |=> rd_data == '0);
endmodule

// File: tb/rx_status_reg_tb_top.sv
`timescale 1ns/1ps
module rx_status_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       cfg_crc_xfer = 1'b0;
    logic       rcv_reset = 1'b0;
    logic       fs_load = 1'b0;
    logic       ev_framing = 1'b0, ev_resid_info = 1'b0, ev_resid_fcs = 1'b0;
    logic       ev_overrun = 1'b0, ev_crc = 1'b0, ev_abort = 1'b0, ev_eom = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       eom_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] model = 8'h00;
    bit compare_on = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rx_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_crc_xfer(cfg_crc_xfer),
        .rcv_reset(rcv_reset), .fs_load(fs_load), .ev_framing(ev_framing),
        .ev_resid_info(ev_resid_info), .ev_resid_fcs(ev_resid_fcs),
        .ev_overrun(ev_overrun), .ev_crc(ev_crc), .ev_abort(ev_abort),
        .ev_eom(ev_eom), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .eom_flag(eom_flag)
    );

    // Behavioural reference built from the requirements.
    always @(posedge clk) begin
        logic [7:0] s;
        logic [7:0] c;
        logic       res;
        s = 8'h00;
        c = 8'h00;
        res = cfg_crc_xfer ? ev_resid_info : ev_resid_fcs;
        if (mode == 2'd0) begin
            if (ev_framing) s[4] = 1'b1;
            if (ev_overrun) s[3] = 1'b1;
        end else if (mode == 2'd1) begin
            if (ev_overrun) s[3] = 1'b1;
            if (ev_crc)     s[2] = 1'b1;
            if (ev_eom)     s[7] = 1'b1;
        end else if (mode == 2'd2) begin
            if (ev_overrun) s[3] = 1'b1;
            if (ev_crc)     s[2] = 1'b1;
            if (ev_eom)     s[7] = 1'b1;
            if (ev_abort) begin s[5] = 1'b1; s[7] = 1'b1; end
            if (res)      begin s[4] = 1'b1; s[7] = 1'b1; end
        end
        if (wr_en) c = wr_data;
        if (fs_load && mode == 2'd2) c = 8'hFF;
        if (!rst_n || rcv_reset) model = 8'h00;
        else model = ((model & ~c) | s) & 8'hBC;
    end

    task automatic report(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, tagged by the owning bit.
    always @(negedge clk) begin
        cycles++;
        if (compare_on) begin
            report("R1 reserved bits", rd_data & 8'h43, model & 8'h43);
            report("R7 eom bit", {7'd0, rd_data[7]}, {7'd0, model[7]});
            report("R6 abort bit", {7'd0, rd_data[5]}, {7'd0, model[5]});
            report("R3 bit4", {7'd0, rd_data[4]}, {7'd0, model[4]});
            report("R2 overrun bit", {7'd0, rd_data[3]}, {7'd0, model[3]});
            report("R5 crc bit", {7'd0, rd_data[2]}, {7'd0, model[2]});
            report("R13 eom_flag", {7'd0, eom_flag}, {7'd0, rd_data[7]});
        end
        if (cycles >= 200000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic idle();
        rcv_reset = 0; fs_load = 0; ev_framing = 0; ev_resid_info = 0;
        ev_resid_fcs = 0; ev_overrun = 0; ev_crc = 0; ev_abort = 0;
        ev_eom = 0; wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    task automatic step_chk(string tag, logic [7:0] exp);
        tick();
        report(tag, rd_data, exp);
        idle();
    endtask

    initial begin
        idle();
        rst_n = 0;
        tick(); tick(); tick();
        compare_on = 1'b1;
        report("R12 reset state", rd_data, 8'h00);
        rst_n = 1;

        // asynchronous mode
        mode = 2'd0;
        ev_framing = 1;  step_chk("R3 framing async", 8'h10);
        ev_overrun = 1;  step_chk("R2 overrun async", 8'h18);
        ev_crc = 1;      step_chk("R5 crc ignored async", 8'h18);
        ev_abort = 1;    step_chk("R6 abort ignored async", 8'h18);
        ev_eom = 1;      step_chk("R7 eom ignored async", 8'h18);
        tick(); tick();  report("R8 sticky hold", rd_data, 8'h18);
        wr_en = 1; wr_data = 8'h00; step_chk("R8 write zero no effect", 8'h18);
        wr_en = 1; wr_data = 8'h43; step_chk("R1 reserved write", 8'h18);
        wr_en = 1; wr_data = 8'h08; step_chk("R8 w1c overrun", 8'h10);
        fs_load = 1;     step_chk("R10 fs_load ignored async", 8'h10);
        rcv_reset = 1;   step_chk("R11 receiver reset", 8'h00);

        // byte synchronous mode
        mode = 2'd1;
        ev_framing = 1;  step_chk("R3 bit4 reserved byte", 8'h00);
        ev_crc = 1;      step_chk("R5 crc byte", 8'h04);
        ev_eom = 1;      step_chk("R7 eom byte", 8'h84);
        report("R13 eom output", {7'd0, eom_flag}, 8'h01);
        ev_resid_fcs = 1; ev_abort = 1; step_chk("R4 residual ignored byte", 8'h84);
        fs_load = 1;     step_chk("R10 fs_load ignored byte", 8'h84);
        wr_en = 1; wr_data = 8'h84; step_chk("R8 w1c two bits", 8'h00);

        // bit synchronous mode
        mode = 2'd2; cfg_crc_xfer = 1;
        ev_resid_fcs = 1;  step_chk("R4 fcs residual ignored when xfer", 8'h00);
        ev_resid_info = 1; step_chk("R4 info residual sets with eom", 8'h90);
        fs_load = 1;       step_chk("R10 fs_load clears", 8'h00);
        cfg_crc_xfer = 0;
        ev_resid_info = 1; step_chk("R4 info residual ignored", 8'h00);
        ev_resid_fcs = 1;  step_chk("R7 fcs residual forces eom", 8'h90);
        ev_abort = 1;      step_chk("R6 abort bit sync", 8'hB0);
        wr_en = 1; wr_data = 8'hFF; ev_crc = 1; step_chk("R9 set beats w1c", 8'h04);
        ev_overrun = 1; fs_load = 1; step_chk("R9 set beats fs_load", 8'h08);
        ev_eom = 1; ev_crc = 1; rcv_reset = 1; step_chk("R11 reset beats set", 8'h00);

        // reserved mode code
        mode = 2'd3;
        ev_framing = 1; ev_resid_info = 1; ev_resid_fcs = 1; ev_overrun = 1;
        ev_crc = 1; ev_abort = 1; ev_eom = 1;
        step_chk("R2 mode 3 sets nothing", 8'h00);

        // chip reset from a non-empty state
        mode = 2'd2; ev_abort = 1; ev_overrun = 1; step_chk("R6 abort again", 8'hA8);
        rst_n = 0; step_chk("R12 sync reset", 8'h00);
        rst_n = 1;

        // random traffic compared every cycle
        for (int n = 0; n < 4000; n++) begin
            mode          = 2'($urandom_range(0, 3));
            cfg_crc_xfer  = 1'($urandom_range(0, 1));
            ev_framing    = ($urandom_range(0, 7) == 0);
            ev_resid_info = ($urandom_range(0, 7) == 0);
            ev_resid_fcs  = ($urandom_range(0, 7) == 0);
            ev_overrun    = ($urandom_range(0, 7) == 0);
            ev_crc        = ($urandom_range(0, 7) == 0);
            ev_abort      = ($urandom_range(0, 11) == 0);
            ev_eom        = ($urandom_range(0, 7) == 0);
            fs_load       = ($urandom_range(0, 9) == 0);
            rcv_reset     = ($urandom_range(0, 29) == 0);
            wr_en         = ($urandom_range(0, 5) == 0);
            wr_data       = 8'($urandom_range(0, 255));
            rst_n         = ($urandom_range(0, 199) != 0);
            tick();
        end
        idle();
        rst_n = 1;
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule